// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block turns a local-bus address into a PCI bus address using three programmable windows. Each window owns two registers. A base register gives the window's local start address, a size code and an enable bit. A map register gives the PCI start address that the window lands on, a cycle-type field and a flag that controls the two low address bits. Every access is compared against all three windows at once. The lowest-numbered enabled window that contains the address supplies the translation. The block returns the PCI address, the number of the window that won, the cycle type (memory, I/O or configuration) and a miss flag.

Windows may overlap on purpose. For example, window 0 can be widened from 256 MB to 512 MB so that it also covers the region window 1 normally serves. Window 1 is then hidden in that range and can be reprogrammed as a small configuration window elsewhere, without disturbing memory traffic. Software programs the registers through a simple write/read port. A write takes effect for accesses presented in the following cycle. Results appear one clock after the access and stay put until the next access.

Top module: `addr_win_xlate`

## Requirements
- R1: After synchronous reset all windows are disabled and every register reads 0. `out_valid` and `out_miss` are 0 until an access is presented, and the first access after reset misses.
- R2: `reg_addr` is {window number, select}, where select 0 picks the base register and select 1 picks the map register. A write is stored masked to its defined fields: base keeps bits 31:20 and 4:0, map keeps bits 31:20 and 3:0. `reg_rdata` shows the selected register one cycle after `reg_addr` is presented. An access presented in the same cycle as a write still uses the old value, and an access in the next cycle uses the new one.
- R3: A window matches when base bit 0 (enable) is 1 and base[31:20]·2^20 ≤ address < base[31:20]·2^20 + 2^(20+code). Here code is base bits 4:1 and is clamped to 12. Code 4 gives 16 MB, code 8 gives 256 MB, code 9 gives 512 MB and code 12 gives 4 GB.
- R4: The translated address is map[31:20]·2^20 plus (address − window start), taken modulo 2^32.
- R5: When several windows match, the lowest-numbered one wins. Its number appears on `out_win`.
- R6: A map type field (bits 3:1) of 101 gives a configuration cycle (`out_type`=3). Any other value gives memory (`out_type`=1) for windows 0 and 1 and I/O (`out_type`=2) for window 2.
- R7: Map bit 0 set passes address bits 1:0 through to the translated address. Map bit 0 clear forces them to 00.
- R8: When no window matches, `out_miss`=1, `out_type`=0 (none), `out_win`=0 and `out_addr`=0.
- R9: Results are registered one cycle after `acc_valid`. `out_valid` is 1 exactly in those cycles, and all result outputs hold their values while no access is presented.
- R10: A 512 MB window 0 hides window 1 wherever the two overlap, and a window revealed elsewhere still translates there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select {window, base/map} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered readback of the selected register |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Local-bus address of the access |
| out_valid | output | 1 | Result of the previous cycle's access |
| out_miss | output | 1 | No enabled window matched |
| out_win | output | 2 | Number of the winning window |
| out_type | output | 2 | 0 none, 1 memory, 2 I/O, 3 configuration |
| out_addr | output | 32 | Translated PCI address |

## Verification
The bench sweeps local addresses in 1 MB steps across and beyond the programmed regions, with varying low bits. It does this under a normal layout, an enlarged 512 MB window 0 with window 1 turned into a configuration window, and a layout with window 0 disabled. This separates the priority order, the range bounds and the per-window type rules. Each window's edges are probed one byte below the start, at the start, at the last byte and one byte past the end, so an off-by-one in the range test shows up. The low-bit control is tried in both settings, and a write issued together with an access shows which configuration that access used. A coarse sweep over the whole 4 GB space with a clamped size code covers the wrap-around and the clamp.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_MEM  = 2'd1,
    CYC_IO   = 2'd2,
    CYC_CFG  = 2'd3
  } cyc_t;

  localparam logic [2:0] CFG_TYPE_CODE = 3'b101;
  localparam int SIZE_W = 4;
endpackage

// File: rtl/win_regs.sv
module win_regs #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 3,
  parameter int ALIGN_W = 20,
  parameter int RA_W    = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr,
  input  logic [RA_W-1:0]                 addr,
  input  logic [ADDR_W-1:0]               wdata,
  output logic [ADDR_W-1:0]               rdata,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  base_q,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  map_q
);
  localparam logic [ADDR_W-1:0] HI_MASK   = {{(ADDR_W-ALIGN_W){1'b1}}, {ALIGN_W{1'b0}}};
  localparam logic [ADDR_W-1:0] BASE_MASK = HI_MASK | ADDR_W'(5'h1F);
  localparam logic [ADDR_W-1:0] MAP_MASK  = HI_MASK | ADDR_W'(4'hF);

  logic [RA_W-2:0] widx;
  logic            sel_map;
  assign widx    = addr[RA_W-1:1];
  assign sel_map = addr[0];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        map_q[g]  <= '0;
      end else if (wr && widx == (RA_W-1)'(g)) begin
        if (sel_map) map_q[g]  <= wdata & MAP_MASK;
        else         base_q[g] <= wdata & BASE_MASK;
      end
    end
  end

  logic [ADDR_W-1:0] rd_sel;
  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (widx == (RA_W-1)'(i)) rd_sel = sel_map ? map_q[i] : base_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_sel;
  end
endmodule

// File: rtl/win_match.sv
module win_match
  import addr_win_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 20,
  parameter bit IS_IO   = 1'b0
) (
  input  logic [ADDR_W-1:0]         acc_addr,
  input  logic                      en,
  input  logic [SIZE_W-1:0]         size_code,
  input  logic [ADDR_W-ALIGN_W-1:0] base_hi,
  input  logic [ADDR_W-ALIGN_W-1:0] map_hi,
  input  logic [2:0]                map_type,
  input  logic                      low_en,
  output logic                      hit,
  output logic [ADDR_W-1:0]         pci_addr,
  output cyc_t                      cyc
);
  localparam int MAXC = ADDR_W - ALIGN_W;
  localparam int SH_W = $clog2(ADDR_W + 1) + 1;

  logic [SH_W-1:0]   sh;
  logic [ADDR_W:0]   diff;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    if (int'(size_code) > MAXC) sh = SH_W'(ALIGN_W + MAXC);
    else                        sh = SH_W'(ALIGN_W) + SH_W'(size_code);
    diff = {1'b0, acc_addr} - {1'b0, base_hi, {ALIGN_W{1'b0}}};
    hit  = en && ((diff >> sh) == '0);
    sum  = {map_hi, {ALIGN_W{1'b0}}} + diff[ADDR_W-1:0];
    pci_addr = low_en ? sum : {sum[ADDR_W-1:2], 2'b00};
    if (map_type == CFG_TYPE_CODE) cyc = CYC_CFG;
    else if (IS_IO)                cyc = CYC_IO;
    else                           cyc = CYC_MEM;
  end
endmodule

// File: rtl/win_prio.sv
module win_prio
  import addr_win_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_WIN-1:0]             hit,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] pci,
  input  cyc_t                           cyc [NUM_WIN],
  output logic                           any,
  output logic [IDX_W-1:0]               idx,
  output logic [ADDR_W-1:0]              addr,
  output cyc_t                           typ
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    addr = '0;
    typ  = CYC_NONE;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        addr = pci[i];
        typ  = cyc[i];
      end
    end
  end
endmodule

// File: rtl/addr_win_xlate.sv
module addr_win_xlate
  import addr_win_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 3,
  parameter int ALIGN_W = 20,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int RA_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              out_valid,
  output logic              out_miss,
  output logic [IDX_W-1:0]  out_win,
  output logic [1:0]        out_type,
  output logic [ADDR_W-1:0] out_addr
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] base_q, map_q, pci;
  logic [NUM_WIN-1:0]             hit;
  cyc_t                           cyc [NUM_WIN];

  win_regs #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .ALIGN_W(ALIGN_W), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .base_q(base_q), .map_q(map_q)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    win_match #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .IS_IO(g == NUM_WIN - 1)) u_match (
      .acc_addr (acc_addr),
      .en       (base_q[g][0]),
      .size_code(base_q[g][SIZE_W:1]),
      .base_hi  (base_q[g][ADDR_W-1:ALIGN_W]),
      .map_hi   (map_q[g][ADDR_W-1:ALIGN_W]),
      .map_type (map_q[g][3:1]),
      .low_en   (map_q[g][0]),
      .hit      (hit[g]),
      .pci_addr (pci[g]),
      .cyc      (cyc[g])
    );
  end

  logic              any;
  logic [IDX_W-1:0]  sel_idx;
  logic [ADDR_W-1:0] sel_addr;
  cyc_t              sel_typ;

  win_prio #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_prio (
    .hit(hit), .pci(pci), .cyc(cyc),
    .any(any), .idx(sel_idx), .addr(sel_addr), .typ(sel_typ)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_win   <= '0;
      out_type  <= CYC_NONE;
      out_addr  <= '0;
    end else begin
      out_valid <= acc_valid;
      if (acc_valid) begin
        out_miss <= !any;
        out_win  <= sel_idx;
        out_type <= sel_typ;
        out_addr <= sel_addr;
      end
    end
  end
endmodule

// File: rtl/addr_win_xlate_chk.sv
module addr_win_xlate_chk #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 3,
  parameter int IDX_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              out_valid,
  input logic              out_miss,
  input logic [IDX_W-1:0]  out_win,
  input logic [1:0]        out_type,
  input logic [ADDR_W-1:0] out_addr
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> !out_valid && !out_miss);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_valid);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !out_valid && $stable(out_addr) && $stable(out_type)
                   && $stable(out_miss) && $stable(out_win));

  a_r8_miss_clean: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_miss |-> out_type == 2'd0 && out_win == '0 && out_addr == '0);

  a_r6_hit_typed: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_miss |-> out_type != 2'd0 && out_win <= IDX_W'(NUM_WIN - 1));

  a_r6_io_last_window: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_miss && out_type == 2'd2 |-> out_win == IDX_W'(NUM_WIN - 1));
endmodule

bind addr_win_xlate addr_win_xlate_chk #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .out_valid(out_valid),
  .out_miss(out_miss), .out_win(out_win), .out_type(out_type), .out_addr(out_addr)
);

// File: tb/tb_addr_win_xlate.sv
`timescale 1ns/1ps
module tb_addr_win_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        out_valid, out_miss;
  logic [1:0]  out_win, out_type;
  logic [31:0] out_addr;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] bb [3];
  logic [31:0] mm [3];

  always #2 clk = ~clk;

  addr_win_xlate dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .out_valid(out_valid), .out_miss(out_miss),
    .out_win(out_win), .out_type(out_type), .out_addr(out_addr)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // expected result packed as {miss, win, type, addr}
  function automatic logic [63:0] model(logic [31:0] a);
    for (int i = 0; i < 3; i++) begin
      longint unsigned lb, sz, off;
      int code;
      logic [31:0] pa;
      code = int'(bb[i][4:1]);
      if (code > 12) code = 12;
      lb = longint'(bb[i] & 32'hFFF0_0000);
      sz = 64'd1 << (20 + code);
      if (bb[i][0] && longint'(a) >= lb && longint'(a) - lb < sz) begin
        off = longint'(a) - lb;
        pa = 32'(longint'(mm[i] & 32'hFFF0_0000) + off);
        if (!mm[i][0]) pa[1:0] = 2'b00;
        return {27'd0, 1'b0, 2'(i),
                (mm[i][3:1] == 3'b101) ? 2'd3 : ((i == 2) ? 2'd2 : 2'd1), pa};
      end
    end
    return {27'd0, 1'b1, 2'd0, 2'd0, 32'd0};
  endfunction

  task automatic wr_reg(logic [1:0] w, logic sel, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = {w, sel}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (sel) mm[w] = d & 32'hFFF0_000F;
    else     bb[w] = d & 32'hFFF0_001F;
  endtask

  task automatic rd_chk(string tag, logic [1:0] w, logic sel, logic [31:0] exp);
    reg_addr = {w, sel};
    @(negedge clk);
    check(tag, {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic access(string tag, logic [31:0] a);
    acc_valid = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    check(tag, {1'b0, out_valid}, 2'b01);
    check(tag, {27'd0, out_miss, out_win, out_type, out_addr}, model(a));
  endtask

  task automatic sweep(string tag);
    for (int k = 0; k < 566; k++) begin
      logic [31:0] a;
      a = 32'h3F00_0000 + 32'(k) * 32'h0010_0000 + ((32'(k) * 32'h1357) & 32'h000F_FFFF);
      access(tag, a);
    end
  endtask

  task automatic edges(string tag);
    for (int i = 0; i < 3; i++) begin
      logic [31:0] lb, sz;
      int code;
      code = int'(bb[i][4:1]);
      if (code > 12) code = 12;
      lb = bb[i] & 32'hFFF0_0000;
      sz = 32'(64'd1 << (20 + code));
      access(tag, lb - 32'd1);
      access(tag, lb);
      access(tag, lb + sz - 32'd1);
      access(tag, lb + sz);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 3; i++) begin bb[i] = '0; mm[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 out_miss", {63'd0, out_miss}, 64'd0);
    for (int i = 0; i < 3; i++) begin
      rd_chk("R1 base readback", 2'(i), 1'b0, 32'd0);
      rd_chk("R1 map readback", 2'(i), 1'b1, 32'd0);
    end
    access("R1 first access misses", 32'h4000_0000);

    // R2: program the normal layout and read it back (unused bits dropped)
    wr_reg(2'd0, 1'b0, 32'h4000_0011);          // 256 MB, enabled
    wr_reg(2'd0, 1'b1, 32'h0000_0003);          // memory, low bits pass
    wr_reg(2'd1, 1'b0, 32'h5000_0011);
    wr_reg(2'd1, 1'b1, 32'h1000_0007);
    wr_reg(2'd2, 1'b0, 32'h600A_BC09);          // 16 MB
    wr_reg(2'd2, 1'b1, 32'h0001_2344);          // low bits forced to 00
    for (int i = 0; i < 3; i++) begin
      rd_chk("R2 base readback", 2'(i), 1'b0, bb[i]);
      rd_chk("R2 map readback", 2'(i), 1'b1, mm[i]);
    end
    check("R2 mask base", {32'd0, bb[2]}, {32'd0, 32'h6000_0009});

    // R3 R4 R5 R6 R7 R8: normal layout
    sweep("R3/R4/R6/R8 normal sweep");
    edges("R3 window edges normal");
    access("R7 low bits pass", 32'h4123_4567);
    access("R7 low bits forced", 32'h6000_0003);

    // R10: widen window 0, window 1 becomes configuration
    wr_reg(2'd0, 1'b0, 32'h4000_0013);          // 512 MB
    wr_reg(2'd1, 1'b0, 32'h6100_0009);          // 16 MB at 0x61000000
    wr_reg(2'd1, 1'b1, 32'h00A0_000A);          // type 101, low bits forced
    sweep("R10/R5 config sweep");
    edges("R3 window edges config");
    access("R10 window 0 hides old window 1 range", 32'h5800_0001);
    access("R6 config type", 32'h6100_0807);
    wr_reg(2'd1, 1'b1, 32'h00A0_000B);          // low bits pass
    access("R7 config low bits pass", 32'h6100_0807);
    sweep("R7 config sweep low pass");

    // R5: overlap with window 2 on top of window 0
    wr_reg(2'd2, 1'b0, 32'h4800_0009);
    access("R5 lower window wins", 32'h4800_0002);
    // window 0 disabled: window 2 now wins there
    wr_reg(2'd0, 1'b0, 32'h4000_0012);
    access("R5 disabled window skipped", 32'h4800_0002);
    sweep("R5 disabled sweep");

    // R2: a write in the same cycle as an access uses the old setting
    reg_wr = 1'b1; reg_addr = 3'b100; reg_wdata = 32'h4800_0008;
    acc_valid = 1'b1; acc_addr = 32'h4800_0010;
    @(negedge clk);
    reg_wr = 1'b0; acc_valid = 1'b0;
    check("R2 same-cycle write uses old", {27'd0, out_miss, out_win, out_type, out_addr},
          model(32'h4800_0010));
    bb[2] = 32'h4800_0008;
    access("R2 next-cycle access uses new", 32'h4800_0010);

    // R9: outputs hold while idle
    access("R9 last access", 32'h6100_0004);
    acc_addr = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    check("R9 idle valid low", {63'd0, out_valid}, 64'd0);
    check("R9 idle hold", {27'd0, out_miss, out_win, out_type, out_addr}, model(32'h6100_0004));

    // R3 clamp: code 15 behaves as 4 GB, whole-space coarse sweep
    wr_reg(2'd2, 1'b0, 32'h0000_001F);
    wr_reg(2'd2, 1'b1, 32'hF000_0001);
    for (int k = 0; k < 256; k++) begin
      access("R3/R4 clamp wrap sweep", 32'(k) * 32'h0100_0000 + 32'(k) * 32'h0001_0203);
    end
    access("R4 wrap top", 32'hFFFF_FFFF);

    summary();
  end
endmodule